// File: doc/BRIEF.md
# Batched TLB Invalidation Sequencer

This block receives a stream of fine-grained translation-cache maintenance requests from an issuing pipeline and applies them to a small fully associative TLB. Plain invalidations go into a short queue, and the issuer keeps running while the queue retires one entry per cycle into the TLB. Ordering is enforced only when a fence op arrives. A write fence waits for the store side to report empty. A read fence blocks implicit page-table reads until every queued invalidation has landed. A full fence does both steps and then its own invalidation, in that order.

Software invalidates a range with this sequence: a write fence, a burst of invalidations, then a read fence. The result is the same as one full fence with the same operands, but the invalidations in the burst overlap and do not stall. The TLB has a fill port for the walker and a combinational lookup port. The fill port owns the single array write port whenever it is active.

Top module: `tlb_inval_seq`

## Requirements
- R1: After reset, `req_ready` and `walk_ok` are high, `st_drain_req` is low and every lookup misses.
- R2: Op code 1 (address-space invalidate) removes every valid non-guest entry for which (`req_addr_zero` or the VPN is equal) and (`req_id_zero` or (the entry is not global and its ID is equal)). Global entries survive an ID-specific invalidate.
- R3: Op code 2 (guest invalidate) applies the same rule to guest entries only, using the ID as a virtual-machine identifier. Op 1 never removes a guest entry and op 2 never removes a non-guest entry.
- R4: When the queue is not full, an invalidate is accepted with `req_ready` high in its own cycle. With the queue empty and no fill active, the lookup shows the entry gone after the clock edge that follows acceptance.
- R5: The queue holds 4 invalidations. An active fill holds the queue. With 4 pending, `req_ready` is low for an invalidate but stays high for other ops.
- R6: Op code 0 (write fence) drives `st_drain_req` high and `req_ready` low from acceptance until the first clock edge that sees `st_empty` high. The block is ready again after that edge.
- R7: Op code 3 (read fence) pulls `walk_ok` low combinationally in the cycle it is presented. `walk_ok` and `req_ready` stay low until the queue has emptied and the fence has retired: one edge after the last pending invalidation is applied.
- R8: Op code 4 (full fence) drains stores, then drains the queue, then applies its own operands with the rule of R2. `req_ready` and `walk_ok` stay low throughout. With nothing pending, the entries go away and the block becomes ready at the third edge after acceptance.
- R9: A write fence, then invalidates, then a read fence leaves the TLB in the same state as one full fence with the same operands.
- R10: Op codes 5, 6 and 7 are accepted and change nothing. The write fence and the read fence ignore their address and ID operands.
- R11: A fill writes the chosen slot and marks it valid. A lookup hits when the entry is valid, the guest flag and VPN are equal, and the entry is either global or has an equal ID; it then returns the entry's PPN, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 3 | Operation code (see R2, R3, R6, R7, R8, R10) |
| req_vpn | input | 20 | Virtual page number operand |
| req_id | input | 8 | Address-space or virtual-machine identifier |
| req_addr_zero | input | 1 | Address operand means all addresses |
| req_id_zero | input | 1 | Identifier operand means all identifiers |
| st_drain_req | output | 1 | Asks the store side to drain |
| st_empty | input | 1 | Store side holds no pending stores |
| walk_ok | output | 1 | Implicit page-table reads may proceed |
| fill_valid | input | 1 | Write an entry this cycle |
| fill_slot | input | 3 | Entry index to write |
| fill_vpn | input | 20 | Fill VPN |
| fill_id | input | 8 | Fill identifier |
| fill_guest | input | 1 | Fill is a guest entry |
| fill_global | input | 1 | Fill is global |
| fill_ppn | input | 20 | Fill physical page number |
| lk_vpn | input | 20 | Lookup VPN |
| lk_id | input | 8 | Lookup identifier |
| lk_guest | input | 1 | Lookup guest flag |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Lookup PPN, 0 on miss |

## Verification
The lookup is combinational, so the bench reads it half a cycle after any edge. An invalidation accepted at edge k is checked as still present just after k and gone just after k+1. A full fence with nothing pending is checked at k+1, k+2 (still stalled, entry present) and k+3 (ready, entry gone). For the write fence, the bench holds `st_empty` low, then looks for the return to ready one edge after `st_empty` rises. For the read fence, it checks `walk_ok` combinationally before acceptance, then counts the edges through four queued pops plus the retiring edge. Random batches are compared with a bench reference TLB only after the closing fence has retired.

// File: rtl/tlb_inval_pkg.sv
// Shared widths, op codes, request record and sequencer states.
package tlb_inval_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;
    localparam int ID_W  = 8;

    // Op codes on the request port; 5..7 are accepted with no effect.
    localparam logic [2:0] OP_WFENCE    = 3'd0;
    localparam logic [2:0] OP_INV       = 3'd1;
    localparam logic [2:0] OP_INV_GUEST = 3'd2;
    localparam logic [2:0] OP_RFENCE    = 3'd3;
    localparam logic [2:0] OP_FULL      = 3'd4;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [ID_W-1:0]  id;
        logic             all_addr;
        logic             all_id;
        logic             guest;
    } inval_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDRAIN,
        ST_RDRAIN,
        ST_FSTORE,
        ST_FQUEUE,
        ST_FAPPLY
    } seq_state_e;
endpackage

// File: rtl/inval_fifo.sv
// Queue of pending invalidation commands.
// Assumes DEPTH >= 2; push and pop may happen in the same cycle.
// The caller never pushes into a full queue without a pop, nor pops an empty one.
module inval_fifo
    import tlb_inval_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  inval_cmd_t push_cmd,
    input  logic       pop,
    output inval_cmd_t head,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    inval_cmd_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Storage write, no reset needed on payload.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_cmd;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Status and head view.
    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tlb_array.sv
// Fully associative TLB model with one fill port, one invalidate port and a
// combinational lookup. Fill takes priority over invalidation on the same entry.
// Assumes the caller keeps fill and invalidate on separate cycles.
module tlb_array
    import tlb_inval_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fill_valid,
    input  logic [$clog2(ENTRIES)-1:0] fill_slot,
    input  logic [VPN_W-1:0]           fill_vpn,
    input  logic [ID_W-1:0]            fill_id,
    input  logic                       fill_guest,
    input  logic                       fill_global,
    input  logic [PPN_W-1:0]           fill_ppn,
    input  logic                       inv_valid,
    input  inval_cmd_t                 inv_cmd,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [ID_W-1:0]            lk_id,
    input  logic                       lk_guest,
    output logic                       lk_hit,
    output logic [PPN_W-1:0]           lk_ppn
);
    localparam int SLOT_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_guest;
    logic [ENTRIES-1:0] ent_global;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [ID_W-1:0]    ent_id  [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] lk_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // Invalidate match: kind, address scope, identifier scope with global exemption.
        assign kill[i] = inv_valid && ent_valid[i]
                      && (ent_guest[i] == inv_cmd.guest)
                      && (inv_cmd.all_addr || (ent_vpn[i] == inv_cmd.vpn))
                      && (inv_cmd.all_id || (!ent_global[i] && (ent_id[i] == inv_cmd.id)));

        // Lookup match on kind, page and identifier unless global.
        assign lk_match[i] = ent_valid[i] && (ent_guest[i] == lk_guest)
                          && (ent_vpn[i] == lk_vpn)
                          && (ent_global[i] || (ent_id[i] == lk_id));

        // Entry state: fill wins, otherwise a matching invalidate clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
            end else if (fill_valid && (fill_slot == SLOT_W'(i))) begin
                ent_valid[i]  <= 1'b1;
                ent_guest[i]  <= fill_guest;
                ent_global[i] <= fill_global;
                ent_vpn[i]    <= fill_vpn;
                ent_id[i]     <= fill_id;
                ent_ppn[i]    <= fill_ppn;
            end else if (kill[i]) begin
                ent_valid[i] <= 1'b0;
            end
        end
    end

    // Lookup result: OR of matching entries' PPN.
    always_comb begin
        lk_ppn = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (lk_match[j]) begin
                lk_ppn = lk_ppn | ent_ppn[j];
            end
        end
    end

    assign lk_hit = |lk_match;

    a_r11_fill_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !fill_valid);
endmodule

// File: rtl/fence_ctrl.sv
// Fence sequencer: accepts requests, pushes invalidations, and stalls the
// issuer only for write, read and full fences. Assumes the queue reports
// empty/full for the current cycle and that a full fence sees no new pushes.
module fence_ctrl
    import tlb_inval_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  inval_cmd_t req_cmd,
    input  logic       q_empty,
    input  logic       q_full,
    input  logic       st_empty,
    input  logic       fill_valid,
    output logic       req_ready,
    output logic       q_push,
    output logic       st_drain_req,
    output logic       walk_ok,
    output logic       fence_apply,
    output inval_cmd_t fence_cmd
);
    seq_state_e state;
    logic       is_inv;
    logic       accept;

    // Request decode and handshake.
    assign is_inv    = (req_op == OP_INV) || (req_op == OP_INV_GUEST);
    assign req_ready = (state == ST_IDLE) && !(is_inv && q_full);
    assign accept    = req_valid && req_ready;
    assign q_push    = accept && is_inv;

    // Sequencer state and latched full-fence operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fence_cmd <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && (req_op == OP_WFENCE)) begin
                        state <= ST_WDRAIN;
                    end else if (accept && (req_op == OP_RFENCE)) begin
                        state <= ST_RDRAIN;
                    end else if (accept && (req_op == OP_FULL)) begin
                        state     <= ST_FSTORE;
                        fence_cmd <= req_cmd;
                    end
                end
                ST_WDRAIN: if (st_empty)    state <= ST_IDLE;
                ST_RDRAIN: if (q_empty)     state <= ST_IDLE;
                ST_FSTORE: if (st_empty)    state <= ST_FQUEUE;
                ST_FQUEUE: if (q_empty)     state <= ST_FAPPLY;
                ST_FAPPLY: if (!fill_valid) state <= ST_IDLE;
                default:                    state <= ST_IDLE;
            endcase
        end
    end

    // Output gates derived from state.
    assign st_drain_req = (state == ST_WDRAIN) || (state == ST_FSTORE);
    assign fence_apply  = (state == ST_FAPPLY) && !fill_valid;
    assign walk_ok = !((state == ST_RDRAIN) || (state == ST_FSTORE)
                    || (state == ST_FQUEUE) || (state == ST_FAPPLY))
                  && !((state == ST_IDLE) && req_valid && (req_op == OP_RFENCE));

    a_r6_drain_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        st_drain_req |-> !req_ready);
    a_r6_release_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_drain_req) |-> $past(st_empty));
    a_r8_apply_on_empty_queue: assert property (@(posedge clk) disable iff (!rst_n)
        fence_apply |-> q_empty);
    a_r7_walk_reopens_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(walk_ok) && ($past(state) != ST_IDLE)) |-> q_empty);
endmodule

// File: rtl/tlb_inval_seq.sv
// Top of the batched invalidation sequencer: controller, invalidate queue and
// TLB model. The queue retires one entry per cycle unless a fill owns the
// array port; a full fence drives the port only once the queue is empty.
module tlb_inval_seq
    import tlb_inval_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int QDEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [2:0]                 req_op,
    input  logic [VPN_W-1:0]           req_vpn,
    input  logic [ID_W-1:0]            req_id,
    input  logic                       req_addr_zero,
    input  logic                       req_id_zero,
    output logic                       st_drain_req,
    input  logic                       st_empty,
    output logic                       walk_ok,
    input  logic                       fill_valid,
    input  logic [$clog2(ENTRIES)-1:0] fill_slot,
    input  logic [VPN_W-1:0]           fill_vpn,
    input  logic [ID_W-1:0]            fill_id,
    input  logic                       fill_guest,
    input  logic                       fill_global,
    input  logic [PPN_W-1:0]           fill_ppn,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [ID_W-1:0]            lk_id,
    input  logic                       lk_guest,
    output logic                       lk_hit,
    output logic [PPN_W-1:0]           lk_ppn
);
    inval_cmd_t req_cmd;
    inval_cmd_t head_cmd;
    inval_cmd_t fence_cmd;
    inval_cmd_t inv_cmd;
    logic       q_push;
    logic       q_pop;
    logic       q_empty;
    logic       q_full;
    logic       fence_apply;
    logic       inv_valid;

    // Pack request operands; guest flag follows the op code.
    always_comb begin
        req_cmd.vpn      = req_vpn;
        req_cmd.id       = req_id;
        req_cmd.all_addr = req_addr_zero;
        req_cmd.all_id   = req_id_zero;
        req_cmd.guest    = (req_op == OP_INV_GUEST);
    end

    // Array port arbitration: fill, then fence, then queue head.
    assign q_pop     = !q_empty && !fill_valid;
    assign inv_valid = q_pop || fence_apply;
    assign inv_cmd   = fence_apply ? fence_cmd : head_cmd;

    fence_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_cmd      (req_cmd),
        .q_empty      (q_empty),
        .q_full       (q_full),
        .st_empty     (st_empty),
        .fill_valid   (fill_valid),
        .req_ready    (req_ready),
        .q_push       (q_push),
        .st_drain_req (st_drain_req),
        .walk_ok      (walk_ok),
        .fence_apply  (fence_apply),
        .fence_cmd    (fence_cmd)
    );

    inval_fifo #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_cmd (req_cmd),
        .pop      (q_pop),
        .head     (head_cmd),
        .empty    (q_empty),
        .full     (q_full)
    );

    tlb_array #(.ENTRIES(ENTRIES)) u_tlb (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_valid  (fill_valid),
        .fill_slot   (fill_slot),
        .fill_vpn    (fill_vpn),
        .fill_id     (fill_id),
        .fill_guest  (fill_guest),
        .fill_global (fill_global),
        .fill_ppn    (fill_ppn),
        .inv_valid   (inv_valid),
        .inv_cmd     (inv_cmd),
        .lk_vpn      (lk_vpn),
        .lk_id       (lk_id),
        .lk_guest    (lk_guest),
        .lk_hit      (lk_hit),
        .lk_ppn      (lk_ppn)
    );

    a_r4_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && !q_pop) |=> !q_empty);
    a_r8_no_push_in_fence: assert property (@(posedge clk) disable iff (!rst_n)
        fence_apply |-> !q_push);
endmodule

// File: tb/tlb_inval_seq_tb_top.sv
`timescale 1ns/1ps
module tlb_inval_seq_tb_top;
    import tlb_inval_pkg::*;

    localparam int NE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = 3'd0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [ID_W-1:0] req_id = '0;
    logic req_addr_zero = 1'b0;
    logic req_id_zero = 1'b0;
    logic st_drain_req;
    logic st_empty = 1'b1;
    logic walk_ok;
    logic fill_valid = 1'b0;
    logic [2:0] fill_slot = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ID_W-1:0] fill_id = '0;
    logic fill_guest = 1'b0;
    logic fill_global = 1'b0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ID_W-1:0] lk_id = '0;
    logic lk_guest = 1'b0;
    logic lk_hit;
    logic [PPN_W-1:0] lk_ppn;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference TLB contents.
    logic             r_val [NE];
    logic [VPN_W-1:0] r_vpn [NE];
    logic [ID_W-1:0]  r_id  [NE];
    logic             r_gst [NE];
    logic             r_glb [NE];
    logic [PPN_W-1:0] r_ppn [NE];

    tlb_inval_seq dut_i (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_kill(int s, logic [VPN_W-1:0] v, logic [ID_W-1:0] id,
                                    bit az, bit iz, bit g);
        return r_val[s] && (r_gst[s] == g) && (az || r_vpn[s] == v)
            && (iz || (!r_glb[s] && r_id[s] == id));
    endfunction

    task automatic ref_apply(input logic [VPN_W-1:0] v, input logic [ID_W-1:0] id,
                             input bit az, input bit iz, input bit g);
        for (int s = 0; s < NE; s++) begin
            if (ref_kill(s, v, id, az, iz, g)) r_val[s] = 1'b0;
        end
    endtask

    task automatic fill(input int s, input logic [VPN_W-1:0] v, input logic [ID_W-1:0] id,
                        input bit g, input bit glb, input logic [PPN_W-1:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_slot = 3'(s); fill_vpn = v; fill_id = id;
        fill_guest = g; fill_global = glb; fill_ppn = p;
        @(posedge clk); #1;
        fill_valid = 1'b0;
        r_val[s] = 1'b1; r_vpn[s] = v; r_id[s] = id; r_gst[s] = g; r_glb[s] = glb; r_ppn[s] = p;
    endtask

    task automatic fill_random();
        for (int s = 0; s < NE; s++) begin
            fill(s, {17'($urandom % 8), 3'(s)}, 8'($urandom % 4), ($urandom % 4) == 0,
                 ($urandom % 4) == 0, 20'($urandom));
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [VPN_W-1:0] v,
                         input logic [ID_W-1:0] id, input bit az, input bit iz);
        @(negedge clk);
        req_op = op; req_vpn = v; req_id = id; req_addr_zero = az; req_id_zero = iz;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk); #1;
        while (!(req_ready && walk_ok)) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic point_at(input int s);
        lk_vpn = r_vpn[s]; lk_id = r_id[s]; lk_guest = r_gst[s];
        #0.1;
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < NE; s++) begin
            point_at(s);
            check(lk_hit == r_val[s], req, $sformatf("slot %0d hit", s), 32'(lk_hit), 32'(r_val[s]));
            if (r_val[s]) check(lk_ppn == r_ppn[s], req, $sformatf("slot %0d ppn", s),
                                32'(lk_ppn), 32'(r_ppn[s]));
        end
    endtask

    task automatic snap(output logic [NE-1:0] h);
        for (int s = 0; s < NE; s++) begin
            point_at(s);
            h[s] = lk_hit;
        end
    endtask

    // Saved contents for the equivalence runs.
    logic [VPN_W-1:0] g_vpn [NE];
    logic [ID_W-1:0]  g_id  [NE];
    logic             g_gst [NE];
    logic             g_glb [NE];
    logic [PPN_W-1:0] g_ppn [NE];

    task automatic fill_saved();
        for (int s = 0; s < NE; s++) fill(s, g_vpn[s], g_id[s], g_gst[s], g_glb[s], g_ppn[s]);
    endtask

    initial begin
        logic [NE-1:0] h1, h2;
        void'($urandom(32'h5EED1234));
        for (int s = 0; s < NE; s++) begin
            r_val[s] = 0; r_vpn[s] = 20'(s); r_id[s] = 0; r_gst[s] = 0; r_glb[s] = 0; r_ppn[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state.
        check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
        check(walk_ok == 1'b1, "R1", "walk_ok", 32'(walk_ok), 1);
        check(st_drain_req == 1'b0, "R1", "st_drain_req", 32'(st_drain_req), 0);
        check_all("R1");

        // R11: fills and lookup, including global match with another ID.
        fill_random();
        check_all("R11");
        fill(2, 20'h00A02, 8'd5, 1'b0, 1'b1, 20'h12345);
        lk_vpn = 20'h00A02; lk_id = 8'd9; lk_guest = 1'b0; #0.1;
        check(lk_hit && lk_ppn == 20'h12345, "R11", "global hit other id", 32'(lk_ppn), 32'h12345);

        // R2: ID-specific invalidate spares a global entry.
        fill(0, 20'h00100, 8'd5, 1'b0, 1'b1, 20'h1);
        fill(1, 20'h00101, 8'd5, 1'b0, 1'b0, 20'h2);
        issue(OP_WFENCE, '0, '0, 0, 0);
        issue(OP_INV, '0, 8'd5, 1, 0); ref_apply('0, 8'd5, 1, 0, 0);
        issue(OP_RFENCE, '0, '0, 0, 0);
        wait_idle();
        check(r_val[0] == 1 && r_val[1] == 0, "R2", "ref global rule", {r_val[0], r_val[1]}, 2);
        check_all("R2");

        // R3: address-space and guest invalidates touch their own kind only.
        fill(3, 20'h00203, 8'd3, 1'b1, 1'b0, 20'h33);
        fill(4, 20'h00204, 8'd3, 1'b0, 1'b0, 20'h44);
        issue(OP_INV, '0, '0, 1, 1); ref_apply('0, '0, 1, 1, 0);
        issue(OP_RFENCE, '0, '0, 0, 0);
        wait_idle();
        point_at(3);
        check(lk_hit == 1'b1, "R3", "guest survives op1", 32'(lk_hit), 1);
        issue(OP_INV_GUEST, 20'h00203, 8'd3, 0, 0); ref_apply(20'h00203, 8'd3, 0, 0, 1);
        issue(OP_RFENCE, '0, '0, 0, 0);
        wait_idle();
        point_at(3);
        check(lk_hit == 1'b0, "R3", "guest removed by op2", 32'(lk_hit), 0);
        check_all("R3");

        // R4: invalidate lands one edge after acceptance, no stall.
        fill(5, 20'h00305, 8'd1, 1'b0, 1'b0, 20'h55);
        point_at(5);
        issue(OP_INV, 20'h00305, '0, 0, 1);
        check(req_ready == 1'b1, "R4", "no stall after invalidate", 32'(req_ready), 1);
        check(lk_hit == 1'b1, "R4", "hit before apply edge", 32'(lk_hit), 1);
        @(posedge clk); #1;
        check(lk_hit == 1'b0, "R4", "miss after apply edge", 32'(lk_hit), 0);
        ref_apply(20'h00305, '0, 0, 1, 0);

        // R5 and R7: fill holds the queue; fifth invalidate stalls; read fence gates walks.
        @(negedge clk);
        fill_valid = 1'b1; fill_slot = 3'd7; fill_vpn = r_vpn[7]; fill_id = r_id[7];
        fill_guest = r_gst[7]; fill_global = r_glb[7]; fill_ppn = r_ppn[7];
        r_val[7] = 1'b1;
        for (int n = 0; n < 4; n++) issue(OP_INV, 20'hFFFF0, '0, 0, 1);
        @(negedge clk);
        req_op = OP_INV; req_vpn = 20'hFFFF0; req_addr_zero = 0; req_id_zero = 1; req_valid = 1'b1;
        #1;
        check(req_ready == 1'b0, "R5", "fifth invalidate stalls", 32'(req_ready), 0);
        @(negedge clk); #1;
        check(req_ready == 1'b0, "R5", "still stalled while fill held", 32'(req_ready), 0);
        req_op = OP_RFENCE; #0.5;
        check(req_ready == 1'b1, "R5", "fence accepted with full queue", 32'(req_ready), 1);
        check(walk_ok == 1'b0, "R7", "walk gate low on presentation", 32'(walk_ok), 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(walk_ok == 1'b0 && req_ready == 1'b0, "R7", "gate and stall after accept",
              {walk_ok, req_ready}, 0);
        @(negedge clk);
        fill_valid = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(walk_ok == 1'b0, "R7", "gate low through last pop", 32'(walk_ok), 0);
        @(posedge clk); #1;
        check(walk_ok == 1'b1 && req_ready == 1'b1, "R7", "gate reopens after retire",
              {walk_ok, req_ready}, 3);
        check_all("R5");

        // R7: read fence with empty queue retires in one edge.
        @(negedge clk);
        req_op = OP_RFENCE; req_valid = 1'b1; #1;
        check(walk_ok == 1'b0, "R7", "gate low on presentation, empty queue", 32'(walk_ok), 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(walk_ok == 1'b0, "R7", "gate low one cycle", 32'(walk_ok), 0);
        @(posedge clk); #1;
        check(walk_ok == 1'b1, "R7", "gate back", 32'(walk_ok), 1);

        // R6: write fence waits for store side.
        st_empty = 1'b0;
        issue(OP_WFENCE, '0, '0, 0, 0);
        for (int n = 0; n < 3; n++) begin
            check(st_drain_req == 1'b1 && req_ready == 1'b0, "R6", "drain and stall",
                  {st_drain_req, req_ready}, 2);
            @(posedge clk); #1;
        end
        @(negedge clk);
        st_empty = 1'b1;
        #1;
        check(req_ready == 1'b0, "R6", "still stalled before edge", 32'(req_ready), 0);
        @(posedge clk); #1;
        check(st_drain_req == 1'b0 && req_ready == 1'b1, "R6", "released at edge",
              {st_drain_req, req_ready}, 1);

        // R8: full fence timing with nothing pending.
        fill(0, 20'h00400, 8'd1, 1'b0, 1'b0, 20'h77);
        point_at(0);
        issue(OP_FULL, '0, '0, 1, 1);
        check(req_ready == 1'b0 && walk_ok == 1'b0, "R8", "stall after accept",
              {req_ready, walk_ok}, 0);
        check(lk_hit == 1'b1, "R8", "entry present at k", 32'(lk_hit), 1);
        @(posedge clk); #1;
        check(req_ready == 1'b0 && lk_hit == 1'b1, "R8", "k+1", {req_ready, lk_hit}, 1);
        @(posedge clk); #1;
        check(req_ready == 1'b0 && lk_hit == 1'b1, "R8", "k+2", {req_ready, lk_hit}, 1);
        @(posedge clk); #1;
        check(req_ready == 1'b1 && lk_hit == 1'b0, "R8", "k+3", {req_ready, lk_hit}, 2);
        ref_apply('0, '0, 1, 1, 0);
        check_all("R8");

        // R10: unassigned op codes and fence operands change nothing.
        fill_random();
        for (int c = 5; c < 8; c++) issue(3'(c), '0, '0, 1, 1);
        issue(OP_WFENCE, '0, '0, 1, 1);
        issue(OP_RFENCE, '0, '0, 1, 1);
        wait_idle();
        check_all("R10");

        // R9: split sequence equals full fence, three operand sets.
        for (int t = 0; t < 3; t++) begin
            logic [VPN_W-1:0] v;
            logic [ID_W-1:0] id;
            bit az, iz;
            fill_random();
            for (int s = 0; s < NE; s++) begin
                g_vpn[s] = r_vpn[s]; g_id[s] = r_id[s]; g_gst[s] = r_gst[s];
                g_glb[s] = r_glb[s]; g_ppn[s] = r_ppn[s];
            end
            v = r_vpn[$urandom % NE]; id = 8'($urandom % 4); az = (t == 1); iz = (t == 2);
            issue(OP_WFENCE, '0, '0, 0, 0);
            issue(OP_INV, v, id, az, iz);
            issue(OP_RFENCE, '0, '0, 0, 0);
            wait_idle();
            snap(h1);
            fill_saved();
            issue(OP_FULL, v, id, az, iz);
            wait_idle();
            snap(h2);
            ref_apply(v, id, az, iz, 0);
            check(h1 == h2, "R9", "split vs full", 32'(h1), 32'(h2));
            check_all("R9");
        end

        // Random batches: R2 and R3 against the reference, with store-drain delays (R6).
        for (int round = 0; round < 60; round++) begin
            fill_random();
            if ($urandom % 4 == 0) begin
                logic [VPN_W-1:0] v;
                v = ($urandom % 2) ? r_vpn[$urandom % NE] : 20'($urandom);
                issue(OP_FULL, v, 8'($urandom % 4), ($urandom % 5) == 0, ($urandom % 4) == 0);
                ref_apply(req_vpn, req_id, req_addr_zero, req_id_zero, 0);
            end else begin
                int d;
                int nb;
                d = 1 + ($urandom % 5);
                if ($urandom % 2) begin
                    st_empty = 1'b0;
                    fork
                        begin
                            repeat (d) @(negedge clk);
                            st_empty = 1'b1;
                        end
                    join_none
                end
                issue(OP_WFENCE, '0, '0, 0, 0);
                nb = 1 + ($urandom % 4);
                for (int n = 0; n < nb; n++) begin
                    logic [2:0] op;
                    logic [VPN_W-1:0] v;
                    op = ($urandom % 3 == 0) ? OP_INV_GUEST : OP_INV;
                    v = ($urandom % 2) ? r_vpn[$urandom % NE] : 20'($urandom);
                    issue(op, v, 8'($urandom % 4), ($urandom % 5) == 0, ($urandom % 4) == 0);
                    ref_apply(req_vpn, req_id, req_addr_zero, req_id_zero, op == OP_INV_GUEST);
                    repeat ($urandom % 2) @(negedge clk);
                end
                issue(OP_RFENCE, '0, '0, 0, 0);
            end
            wait_idle();
            check_all("R2/R3 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule